// File: doc/BRIEF.md
# Supply Voltage Detector Control Register

This block is the control and status register that sits between a low-voltage detector and the rest of the chip. It keeps one writable bit, the level-unlock bit, which decides whether the companion register that selects the detection threshold may be written. Every level-register write request is gated by this bit before it leaves the block as a write strobe. Two read-only flags report the detector's condition. The under-voltage flag shows the synchronised comparator result. The mask flag shows that the detector's output is currently hidden from the reset and interrupt logic.

The mask exists so that a threshold change or a comparator that is still settling cannot produce a false reset or interrupt. It is only active in the combined interrupt-and-reset detector mode. In that mode it is held for as long as the level-unlock bit is 1. It is also held for a fixed settling window after a detector interrupt or after any change of the level-select value. A three-state machine tracks the unlock condition and the settling condition. LOCKED means the bit is 0 and no window is running. OPEN means the bit is 1. SETTLE means the bit is 0 and a window is counting down. The transitions are: LOCKED to OPEN on an accepted set, LOCKED to SETTLE on a trigger, OPEN to LOCKED or OPEN to SETTLE on a clear (depending on whether a window is still running), SETTLE to OPEN on a set, and SETTLE to LOCKED when the window expires.

Reset is qualified by source. A reset raised by the detector itself freezes the register contents. Every other reset clears them.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: A reset with `rst_by_det`=0 clears the register. While that reset is asserted, and on the first cycle after it, `rd_data` reads 0x00.
- R2: Bit 7 of `rd_data` is the level-unlock bit. It is set to 1 only when `mode` = 2'b10. Two writes can set it: a byte write (`wr_bit`=0) with `wr_data[7]`=1, or a bit write (`wr_bit`=1, `wr_sel`=7) with `wr_data[0]`=1. Either write form with the value 0 clears it in any mode. The new value is visible on the cycle after the write edge.
- R3: While `mode` is not 2'b10, a write of 1 to bit 7 leaves bit 7 unchanged.
- R4: Bits 6 to 2 of `rd_data` always read 0. Writes to bits 1 and 0, whether by byte write or by bit write with `wr_sel` < 7, change no readable state.
- R5: Bit 0 of `rd_data` equals `det_on` AND the comparator output `cmp_low`. `cmp_low` is passed through a two-flop synchroniser, so a change is seen two clock edges later.
- R6: `lvl_wr_stb` equals `lvl_wr_req` while bit 7 reads 1, and is 0 otherwise.
- R7: Bit 1 of `rd_data`, the mask flag, is 1 exactly when `mode` = 2'b10 and either bit 7 is 1 or a settling window is running.
- R8: In `mode` 2'b10, a `det_irq` pulse or a change of `lvl_sel` from its value on the previous edge starts a settling window of SETTLE_CYC cycles. A new trigger during the window restarts it. The window is counted from the edge that samples the trigger.
- R9: `det_out` equals `det_on` AND the synchronised comparator AND NOT the mask flag.
- R10: A reset with `rst_by_det`=1 leaves bit 7 and the settling window frozen. Writes during that reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_by_det | input | 1 | Qualifies the reset: 1 means the detector raised it |
| wr_en | input | 1 | Register write request |
| wr_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| wr_sel | input | 3 | Bit index for a single-bit write |
| wr_data | input | 8 | Byte write data; bit 0 carries the value of a bit write |
| rd_data | output | 8 | Register read value |
| mode | input | 2 | Detector mode; 2'b10 is interrupt-and-reset |
| lvl_sel | input | LVL_W | Current level-select value of the companion register |
| lvl_wr_req | input | 1 | Request to write the level register |
| lvl_wr_stb | output | 1 | Gated level-register write strobe |
| det_irq | input | 1 | Detector interrupt event pulse |
| det_on | input | 1 | Detector enabled |
| cmp_low | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| det_out | output | 1 | Masked detector output to the reset and interrupt logic |

## Verification
Three things can land on the same edge: a clear of the unlock bit, a settling trigger, and the last count of a running window. How the machine leaves OPEN depends on all three together. Random stimulus biases the mode towards 2'b10 and issues frequent bit-7 writes together with sparse `det_irq` pulses and `lvl_sel` changes, so these coincidences occur many times. Directed steps also place a clear and an `lvl_sel` change on one edge. A bench model that tracks the unlock bit and the window length judges every cycle against the mask flag, `det_out` and `lvl_wr_stb`.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_SETTLE = 2'd2
    } lock_state_e;

    localparam logic [1:0] MODE_INT_RST = 2'b10;
    localparam int         UNLOCK_BIT   = 7;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (clr) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lvd_settle_cnt.sv
module lvd_settle_cnt #(
    parameter int SETTLE_CYC = 6,
    localparam int CW = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic clr,
    input  logic hold,
    input  logic trig,
    output logic cnt_zero,
    output logic cnt_last
);
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr)                cnt_q <= '0;
        else if (hold)          cnt_q <= cnt_q;
        else if (trig)          cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CW'(1));

    initial begin
        assert (SETTLE_CYC >= 1) else $error("SETTLE_CYC must be at least 1");
    end

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (clr || hold)
        trig |=> (cnt_q == LOAD_VAL)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (clr || hold)
        (!trig && !cnt_zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
endmodule

// File: rtl/lvd_lock_fsm.sv
module lvd_lock_fsm
    import lvd_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic hold,
    input  logic mode_ir,
    input  logic set_req,
    input  logic clr_req,
    input  logic trig,
    input  logic cnt_zero,
    input  logic cnt_last,
    output logic is_open,
    output logic in_settle
);
    lock_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (clr)       state_q <= ST_LOCKED;
        else if (hold) state_q <= state_q;
        else           state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (set_req)   state_d = ST_OPEN;
                else if (trig) state_d = ST_SETTLE;
            end
            ST_OPEN: begin
                if (clr_req) begin
                    if (trig || (!cnt_zero && !cnt_last)) state_d = ST_SETTLE;
                    else                                  state_d = ST_LOCKED;
                end
            end
            ST_SETTLE: begin
                if (set_req)                    state_d = ST_OPEN;
                else if (trig)                  state_d = ST_SETTLE;
                else if (cnt_last || cnt_zero)  state_d = ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        is_open   = (state_q == ST_OPEN);
        in_settle = (state_q == ST_SETTLE);
    end

    AST_SETTLE_COUNTS: assert property (@(posedge clk) disable iff (clr || hold)
        (state_q == ST_SETTLE) |-> !cnt_zero); // R8
    AST_NO_SET_OFFMODE: assert property (@(posedge clk) disable iff (clr || hold)
        (!mode_ir && state_q != ST_OPEN) |=> (state_q != ST_OPEN)); // R3
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (clr)
        hold |=> (state_q == $past(state_q))); // R10
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
    import lvd_pkg::*;
#(
    parameter int LVL_W      = 3,
    parameter int SETTLE_CYC = 6,
    parameter int SYNC_STG   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_by_det,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic [2:0]       wr_sel,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [1:0]       mode,
    input  logic [LVL_W-1:0] lvl_sel,
    input  logic             lvl_wr_req,
    output logic             lvl_wr_stb,
    input  logic             det_irq,
    input  logic             det_on,
    input  logic             cmp_low,
    output logic             det_out
);
    logic             rst_clr, rst_hold;
    logic             mode_ir;
    logic             hits_unlock, wr_val;
    logic             set_req, clr_req;
    logic [LVL_W-1:0] lvl_prev_q;
    logic             lvl_changed, trig;
    logic             cnt_zero, cnt_last;
    logic             is_open, in_settle;
    logic             cmp_sync, mask_flag, uv_flag;

    assign rst_clr  = !rst_n && !rst_by_det;
    assign rst_hold = !rst_n &&  rst_by_det;
    assign mode_ir  = (mode == MODE_INT_RST);

    // Write decode: only the unlock bit is writable
    always_comb begin
        hits_unlock = wr_en && rst_n && (!wr_bit || (wr_sel == 3'(UNLOCK_BIT)));
        wr_val      = wr_bit ? wr_data[0] : wr_data[UNLOCK_BIT];
        set_req     = hits_unlock &&  wr_val && mode_ir;
        clr_req     = hits_unlock && !wr_val;
    end

    // Level-select change detection
    always_ff @(posedge clk) begin
        if (rst_clr)       lvl_prev_q <= lvl_sel;
        else if (rst_hold) lvl_prev_q <= lvl_prev_q;
        else               lvl_prev_q <= lvl_sel;
    end

    assign lvl_changed = (lvl_sel != lvl_prev_q);
    assign trig        = rst_n && mode_ir && (det_irq || lvl_changed);

    lvd_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .clr     (rst_clr),
        .d_async (cmp_low),
        .q_sync  (cmp_sync)
    );

    lvd_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_cnt (
        .clk      (clk),
        .clr      (rst_clr),
        .hold     (rst_hold),
        .trig     (trig),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    lvd_lock_fsm u_fsm (
        .clk       (clk),
        .clr       (rst_clr),
        .hold      (rst_hold),
        .mode_ir   (mode_ir),
        .set_req   (set_req),
        .clr_req   (clr_req),
        .trig      (trig),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .is_open   (is_open),
        .in_settle (in_settle)
    );

    always_comb begin
        mask_flag  = mode_ir && (is_open || in_settle);
        uv_flag    = det_on && cmp_sync;
        det_out    = uv_flag && !mask_flag;
        lvl_wr_stb = lvl_wr_req && is_open;
        rd_data    = {is_open, 5'b00000, mask_flag, uv_flag};
    end

    AST_STB_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_wr_stb |-> rd_data[7]); // R6
    AST_MASK_BLOCKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] |-> !det_out); // R9
    AST_UNLOCK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && mode_ir) |-> rd_data[1]); // R7
    AST_CLEAR_RESET: assert property (@(posedge clk)
        rst_clr |=> (rd_data[7] == 1'b0)); // R1
endmodule

// File: tb/tb_lvd_ctrl_reg.sv
`timescale 1ns/1ps
module tb_lvd_ctrl_reg;
    localparam int LVL_W = 3;
    localparam int SC    = 6;

    logic             clk = 0;
    logic             rst_n, rst_by_det, wr_en, wr_bit;
    logic [2:0]       wr_sel;
    logic [7:0]       wr_data, rd_data;
    logic [1:0]       mode;
    logic [LVL_W-1:0] lvl_sel;
    logic             lvl_wr_req, lvl_wr_stb, det_irq, det_on, cmp_low, det_out;

    lvd_ctrl_reg #(.LVL_W(LVL_W), .SETTLE_CYC(SC), .SYNC_STG(2)) dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Bench model built from the requirements
    bit m_open, m_s1, m_s2;
    int m_cnt;
    logic [LVL_W-1:0] m_prev;

    function automatic bit f_mask();
        return (mode == 2'b10) && (m_open || m_cnt != 0);
    endfunction
    function automatic logic [7:0] f_rd();
        return {m_open, 5'b0, f_mask(), det_on & m_s2};
    endfunction

    always @(posedge clk) begin
        bit hit, val, tr;
        if (!rst_n && !rst_by_det) begin
            m_open <= 0; m_cnt <= 0; m_s1 <= 0; m_s2 <= 0; m_prev <= lvl_sel;
        end else begin
            m_s1 <= cmp_low; m_s2 <= m_s1;
            if (rst_n) begin
                hit = wr_en && (!wr_bit || wr_sel == 3'd7);
                val = wr_bit ? wr_data[0] : wr_data[7];
                if (hit && val && mode == 2'b10) m_open <= 1;
                else if (hit && !val)            m_open <= 0;
                tr = (mode == 2'b10) && (det_irq || lvl_sel != m_prev);
                if (tr)              m_cnt <= SC;
                else if (m_cnt != 0) m_cnt <= m_cnt - 1;
                m_prev <= lvl_sel;
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [7:0] e;
        e = f_rd();
        chk("R2/R3 unlock bit", {7'b0, rd_data[7]}, {7'b0, e[7]});
        chk("R4 zero bits", {3'b0, rd_data[6:2]}, 8'h00);
        chk("R7/R8 mask flag", {7'b0, rd_data[1]}, {7'b0, e[1]});
        chk("R5 under-voltage", {7'b0, rd_data[0]}, {7'b0, e[0]});
        chk("R6 level strobe", {7'b0, lvl_wr_stb}, {7'b0, lvl_wr_req & m_open});
        chk("R9 det_out", {7'b0, det_out}, {7'b0, det_on & m_s2 & ~f_mask()});
    endtask

    task automatic idle();
        wr_en = 0; det_irq = 0; lvl_wr_req = 0;
    endtask

    // One cycle: drive at negedge, check, then let the edge pass
    task automatic step();
        #1 check_all();
        @(negedge clk);
    endtask

    task automatic wr(bit bitm, logic [2:0] sel, logic [7:0] d);
        wr_en = 1; wr_bit = bitm; wr_sel = sel; wr_data = d;
        step(); idle();
    endtask

    initial begin
        rst_n = 0; rst_by_det = 0; wr_bit = 0; wr_sel = 0; wr_data = 0;
        mode = 2'b10; lvl_sel = 0; det_on = 1; cmp_low = 0;
        idle();
        @(negedge clk); @(negedge clk);
        chk("R1 reset value", rd_data, 8'h00);
        rst_n = 1; step();
        chk("R1 after reset", rd_data, 8'h00);

        // R2 byte and bit writes
        wr(0, 0, 8'h80); chk("R2 byte set", rd_data & 8'h80, 8'h80);
        lvl_wr_req = 1; #1 chk("R6 strobe open", {7'b0, lvl_wr_stb}, 8'h01); step(); idle();
        wr(1, 7, 8'h00); chk("R2 bit clear", rd_data & 8'h80, 8'h00);
        wr(1, 7, 8'h01); chk("R2 bit set", rd_data & 8'h80, 8'h80);
        // clear and level change on one edge
        wr_en = 1; wr_bit = 0; wr_data = 8'h00; lvl_sel = 3'd5; step(); idle();
        chk("R8 settle after clear+change", rd_data & 8'h02, 8'h02);
        for (int i = 0; i < SC + 2; i++) step();
        chk("R8 window ended", rd_data & 8'h02, 8'h00);

        // R3 set ignored in other modes
        mode = 2'b01; wr(0, 0, 8'hFF); chk("R3 ignored byte", rd_data & 8'h80, 8'h00);
        wr(1, 7, 8'h01); chk("R3 ignored bit", rd_data & 8'h80, 8'h00);
        mode = 2'b10;

        // R4 read-only bits
        wr(1, 0, 8'h01); wr(1, 1, 8'h01); wr(0, 0, 8'h7F);
        chk("R4 read-only writes", rd_data, 8'h00);

        // R5 and R9 synchroniser latency
        cmp_low = 1; step();
        chk("R5 one edge", rd_data & 8'h01, 8'h00);
        step();
        chk("R5 two edges", rd_data & 8'h01, 8'h01);
        chk("R9 unmasked out", {7'b0, det_out}, 8'h01);
        det_irq = 1; step(); idle();
        chk("R9 masked by irq window", {7'b0, det_out}, 8'h00);

        // R10 detector reset holds unlock bit
        wr(0, 0, 8'h80);
        rst_n = 0; rst_by_det = 1; wr_en = 1; wr_data = 8'h00; step(); step(); idle();
        chk("R10 hold during det reset", rd_data & 8'h80, 8'h80);
        rst_n = 1; rst_by_det = 0; step();
        chk("R10 held after det reset", rd_data & 8'h80, 8'h80);
        rst_n = 0; step(); rst_n = 1; step();
        chk("R1 clear reset clears bit7", rd_data, 8'h00);

        // Constrained random
        void'($urandom(32'h1A2B));
        for (int i = 0; i < 4000; i++) begin
            mode       = ($urandom % 8 < 6) ? 2'b10 : 2'($urandom);
            wr_en      = ($urandom % 4 == 0);
            wr_bit     = $urandom;
            wr_sel     = ($urandom % 2) ? 3'd7 : 3'($urandom);
            wr_data    = 8'($urandom);
            det_irq    = ($urandom % 25 == 0);
            if ($urandom % 20 == 0) lvl_sel = LVL_W'($urandom);
            lvl_wr_req = $urandom;
            det_on     = ($urandom % 8 != 0);
            if ($urandom % 4 == 0) cmp_low = ~cmp_low;
            rst_n      = ($urandom % 100 != 0);
            rst_by_det = $urandom;
            step();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule